// File: doc/BRIEF.md
# Lane-Partitioned Saturating Vector Adder

This block adds two 64-bit operands held as packed vectors. A two-bit width select splits the operands into eight 8-bit elements, four 16-bit elements, two 32-bit elements, or one 64-bit element. The carry chain is built from 8-bit segments, and the chain is cut wherever a segment starts a new element, so each element is summed on its own.

Two more controls set the arithmetic. A signed control chooses between two's-complement and unsigned reading of the elements. A clip control chooses between wraparound results and results held at the element's range limits. Every element reports an overflow flag. The flags describe the add itself, so they are the same whether or not clipping is on. A parameter can put one register stage in front of the outputs.

Top module: `simd_sat_adder`

## Requirements
- R1: In modes 0, 1 and 2, no carry passes from an element into the element above it. Each element's result depends only on that element's operand bits.
- R2: In mode 3 (one 64-bit element), the carry runs through all 64 bits.
- R3: With `clip_en`=0, each element result is (a+b) modulo 2^w, where w is 8 for mode 0, 16 for mode 1, 32 for mode 2 and 64 for mode 3.
- R4: With `clip_en`=1 and `sgn_en`=0, an element whose sum carries out of its top bit gives all ones.
- R5: With `clip_en`=1 and `sgn_en`=1, an element with positive overflow gives its largest positive value: 0 in the top bit and ones below it.
- R6: With `clip_en`=1 and `sgn_en`=1, an element with negative overflow gives its most negative value: 1 in the top bit and zeros below it.
- R7: An element's overflow flag is its unsigned carry-out when `sgn_en`=0 and its signed overflow when `sgn_en`=1. The flag does not depend on `clip_en`.
- R8: Flag bit k belongs to element k, counting up from the least significant element. Flag bits at or above the element count of the mode read zero.
- R9: With `REG_OUT`=1, `sum_o` and `ovf_o` show an operand set one clock edge after it is applied. During reset both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_a | input | 64 | First packed operand |
| op_b | input | 64 | Second packed operand |
| lane_mode | input | 2 | Element width: 0=8-bit, 1=16-bit, 2=32-bit, 3=64-bit |
| clip_en | input | 1 | 1 = clip on overflow, 0 = wraparound |
| sgn_en | input | 1 | 1 = signed elements, 0 = unsigned |
| sum_o | output | 64 | Packed result |
| ovf_o | output | 8 | Overflow flag for each element |

## Verification
The bench builds the block with the default parameters: a 64-bit datapath, 8-bit segments and the output register on (`REG_OUT`=1). With this build, all four element widths can be reached, and so can the one-cycle latency and the zero outputs during reset. Before each clock edge, the bench also checks that the outputs still hold the previous result. The random operands are biased toward the range limits of each element, so that carries arrive exactly at element boundaries and clipping occurs often in every mode, signed and unsigned.

// File: rtl/simd_add_pkg.sv
`timescale 1ns/1ps
package simd_add_pkg;
  typedef enum logic [1:0] {
    LW_8  = 2'd0,
    LW_16 = 2'd1,
    LW_32 = 2'd2,
    LW_64 = 2'd3
  } lane_w_e;
endpackage

// File: rtl/simd_seg_chain.sv
`timescale 1ns/1ps
module simd_seg_chain
  import simd_add_pkg::*;
#(
  parameter int SEG_W = 8,
  parameter int N_SEG = 8
) (
  input  logic [N_SEG*SEG_W-1:0] a_i,
  input  logic [N_SEG*SEG_W-1:0] b_i,
  input  lane_w_e                mode_i,
  output logic [N_SEG*SEG_W-1:0] seg_sum_o,
  output logic [N_SEG-1:0]       seg_cout_o,
  output logic [N_SEG-1:0]       seg_sovf_o
);
  localparam int IDX_W = (N_SEG > 1) ? $clog2(N_SEG) : 1;

  logic [IDX_W-1:0] lane_mask;
  logic [N_SEG:0]   carry;
  logic [N_SEG-1:0] cut;

  assign lane_mask = IDX_W'((1 << mode_i) - 1);
  assign carry[0]  = 1'b0;

  for (genvar i = 0; i < N_SEG; i++) begin : g_seg
    logic [SEG_W-1:0] sa, sb, ss;
    logic             cin;
    assign cut[i] = ((IDX_W'(i) & lane_mask) == '0);
    assign cin    = carry[i] & ~cut[i];
    assign sa     = a_i[i*SEG_W +: SEG_W];
    assign sb     = b_i[i*SEG_W +: SEG_W];
    assign {carry[i+1], ss} = {1'b0, sa} + {1'b0, sb} + {{SEG_W{1'b0}}, cin};
    assign seg_sum_o[i*SEG_W +: SEG_W] = ss;
    assign seg_cout_o[i] = carry[i+1];
    assign seg_sovf_o[i] = (sa[SEG_W-1] == sb[SEG_W-1]) && (ss[SEG_W-1] != sa[SEG_W-1]);
  end
endmodule

// File: rtl/simd_lane_clip.sv
`timescale 1ns/1ps
module simd_lane_clip
  import simd_add_pkg::*;
#(
  parameter int SEG_W = 8,
  parameter int N_SEG = 8
) (
  input  logic [N_SEG*SEG_W-1:0] a_i,
  input  logic [N_SEG*SEG_W-1:0] seg_sum_i,
  input  logic [N_SEG-1:0]       seg_cout_i,
  input  logic [N_SEG-1:0]       seg_sovf_i,
  input  lane_w_e                mode_i,
  input  logic                   clip_i,
  input  logic                   sgn_i,
  output logic [N_SEG*SEG_W-1:0] sum_o,
  output logic [N_SEG-1:0]       lane_ovf_o
);
  localparam int IDX_W = (N_SEG > 1) ? $clog2(N_SEG) : 1;
  localparam logic [SEG_W-1:0] ONES = {SEG_W{1'b1}};
  localparam logic [SEG_W-1:0] SMAX = {1'b0, {(SEG_W-1){1'b1}}};
  localparam logic [SEG_W-1:0] SMIN = {1'b1, {(SEG_W-1){1'b0}}};

  logic [IDX_W-1:0] lane_mask;
  assign lane_mask = IDX_W'((1 << mode_i) - 1);

  always_comb begin
    sum_o      = seg_sum_i;
    lane_ovf_o = '0;
    for (int i = 0; i < N_SEG; i++) begin
      logic [IDX_W-1:0] top;
      logic             ovf, neg, is_top;
      top    = IDX_W'(i) | lane_mask;
      is_top = (top == IDX_W'(i));
      ovf    = sgn_i ? seg_sovf_i[top] : seg_cout_i[top];
      neg    = a_i[top*SEG_W + SEG_W - 1];
      lane_ovf_o[i] = ovf;
      if (clip_i && ovf) begin
        if (!sgn_i)   sum_o[i*SEG_W +: SEG_W] = ONES;
        else if (neg) sum_o[i*SEG_W +: SEG_W] = is_top ? SMIN : '0;
        else          sum_o[i*SEG_W +: SEG_W] = is_top ? SMAX : ONES;
      end
    end
  end
endmodule

// File: rtl/simd_flag_pack.sv
`timescale 1ns/1ps
module simd_flag_pack
  import simd_add_pkg::*;
#(
  parameter int N_SEG = 8
) (
  input  logic [N_SEG-1:0] lane_ovf_i,
  input  lane_w_e          mode_i,
  output logic [N_SEG-1:0] flag_o
);
  always_comb begin
    flag_o = '0;
    for (int k = 0; k < N_SEG; k++) begin
      if (k < (N_SEG >> mode_i)) flag_o[k] = lane_ovf_i[k << mode_i];
    end
  end
endmodule

// File: rtl/simd_sat_adder.sv
`timescale 1ns/1ps
module simd_sat_adder
  import simd_add_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int SEG_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DATA_W-1:0]         op_a,
  input  logic [DATA_W-1:0]         op_b,
  input  logic [1:0]                lane_mode,
  input  logic                      clip_en,
  input  logic                      sgn_en,
  output logic [DATA_W-1:0]         sum_o,
  output logic [DATA_W/SEG_W-1:0]   ovf_o
);
  localparam int N_SEG = DATA_W / SEG_W;

  lane_w_e             mode;
  logic [DATA_W-1:0]   seg_sum, sum_c;
  logic [N_SEG-1:0]    seg_cout, seg_sovf, lane_ovf, flag_c;

  assign mode = lane_w_e'(lane_mode);

  simd_seg_chain #(.SEG_W(SEG_W), .N_SEG(N_SEG)) u_chain (
    .a_i(op_a), .b_i(op_b), .mode_i(mode),
    .seg_sum_o(seg_sum), .seg_cout_o(seg_cout), .seg_sovf_o(seg_sovf)
  );

  simd_lane_clip #(.SEG_W(SEG_W), .N_SEG(N_SEG)) u_clip (
    .a_i(op_a), .seg_sum_i(seg_sum), .seg_cout_i(seg_cout), .seg_sovf_i(seg_sovf),
    .mode_i(mode), .clip_i(clip_en), .sgn_i(sgn_en),
    .sum_o(sum_c), .lane_ovf_o(lane_ovf)
  );

  simd_flag_pack #(.N_SEG(N_SEG)) u_flags (
    .lane_ovf_i(lane_ovf), .mode_i(mode), .flag_o(flag_c)
  );

  if (REG_OUT) begin : g_reg
    logic [DATA_W-1:0] sum_d, sum_q;
    logic [N_SEG-1:0]  flag_d, flag_q;
    logic              upd_en;
    always_comb begin
      upd_en = 1'b1;
      sum_d  = sum_c;
      flag_d = flag_c;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum_q  <= '0;
        flag_q <= '0;
      end else if (upd_en) begin
        sum_q  <= sum_d;
        flag_q <= flag_d;
      end
    end
    assign sum_o = sum_q;
    assign ovf_o = flag_q;
  end else begin : g_comb
    assign sum_o = sum_c;
    assign ovf_o = flag_c;
  end

  logic [DATA_W:0] full_add;
  assign full_add = {1'b0, op_a} + {1'b0, op_b};

  always_comb begin
    if (rst_n) begin
      AST_LOW_LANE_WRAP: assert (clip_en || sum_c[SEG_W-1:0] == full_add[SEG_W-1:0]); // R3
      AST_UNSIGNED_CLIP: assert (!(clip_en && !sgn_en && flag_c[0]) || sum_c[SEG_W-1:0] == {SEG_W{1'b1}}); // R4
      AST_SIGNED_CLIP: assert (!(clip_en && sgn_en && flag_c[0] && mode == LW_8) || sum_c[SEG_W-1:0] == {1'b0, {(SEG_W-1){1'b1}}} || sum_c[SEG_W-1:0] == {1'b1, {(SEG_W-1){1'b0}}}); // R5
      AST_SPARE_FLAGS: assert (mode != LW_64 || flag_c[N_SEG-1:1] == '0); // R8
      AST_FULL_CARRY: assert (!(mode == LW_64 && !sgn_en && !clip_en) || (flag_c[0] == full_add[DATA_W] && sum_c == full_add[DATA_W-1:0])); // R2
    end
  end
endmodule

// File: tb/tb_simd_sat_adder.sv
`timescale 1ns/1ps
module tb_simd_sat_adder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] op_a, op_b;
  logic [1:0]  lane_mode;
  logic        clip_en, sgn_en;
  logic [63:0] sum_o;
  logic [7:0]  ovf_o;
  int          n_chk = 0, n_fail = 0;
  logic [71:0] prev_exp;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  simd_sat_adder dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .lane_mode(lane_mode),
    .clip_en(clip_en), .sgn_en(sgn_en), .sum_o(sum_o), .ovf_o(ovf_o)
  );

  function automatic logic [71:0] model(input logic [63:0] a, b, input int m, input bit sat, sgn);
    int lw, n;
    logic [64:0] mask, ea, eb, s, r;
    logic [63:0] out;
    logic [7:0]  fl;
    bit ovf, sa, sb, ss;
    lw = 8 << m; n = 64 / lw;
    mask = (65'd1 << lw) - 65'd1;
    out = '0; fl = '0;
    for (int k = 0; k < n; k++) begin
      ea = ({1'b0, a} >> (k*lw)) & mask;
      eb = ({1'b0, b} >> (k*lw)) & mask;
      s  = ea + eb;
      sa = ea[lw-1]; sb = eb[lw-1]; ss = s[lw-1];
      ovf = sgn ? (sa == sb && ss != sa) : s[lw];
      r = s & mask;
      if (sat && ovf) begin
        if (!sgn)    r = mask;
        else if (sa) r = 65'd1 << (lw-1);
        else         r = mask >> 1;
      end
      out = out | (r[63:0] << (k*lw));
      fl[k] = ovf;
    end
    return {fl, out};
  endfunction

  task automatic chk(input logic [71:0] exp, input string tag);
    n_chk++;
    if ({ovf_o, sum_o} !== exp) begin
      n_fail++;
      $display("FAIL %s: got flags=%h sum=%h, expected flags=%h sum=%h",
               tag, ovf_o, sum_o, exp[71:64], exp[63:0]);
    end
  endtask

  task automatic apply(input logic [63:0] a, b, input int m, input bit sat, sgn, input string tag);
    logic [71:0] e;
    @(negedge clk);
    op_a = a; op_b = b; lane_mode = 2'(m); clip_en = sat; sgn_en = sgn;
    e = model(a, b, m, sat, sgn);
    #1 chk(prev_exp, "R9 hold before edge");
    @(posedge clk);
    #1 chk(e, tag);
    prev_exp = e;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b;
    int m, sel;
    bit sat, sgn;
    void'($urandom(32'h5EED_0A11));
    rst_n = 1'b0; op_a = '1; op_b = '1; lane_mode = 2'd0; clip_en = 1'b1; sgn_en = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk(72'd0, "R9 reset state");
    @(negedge clk); rst_n = 1'b1;
    prev_exp = 72'd0;
    op_a = '0; op_b = '0;
    @(posedge clk); #1 chk(72'd0, "R9 zero after reset");

    apply(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 0, 0, 0, "R1 byte lanes no carry");
    apply(64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 1, 0, 0, "R1 halfword lanes");
    apply(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 2, 0, 0, "R1 word lanes");
    apply(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 3, 0, 0, "R2 full carry");
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 3, 0, 0, "R2 wrap carry-out");
    apply(64'hF0F0_F0F0_F0F0_F0F0, 64'h2020_2020_2020_2020, 0, 0, 0, "R3 modulo bytes");
    apply(64'hFFFF_1234_FFFF_0001, 64'h0001_0001_0002_FFFF, 1, 1, 0, "R4 unsigned clip");
    apply(64'h7F01_7F00_7F7F_0000, 64'h0101_0000_0101_0000, 0, 1, 1, "R5 positive clip");
    apply(64'h8000_0000_8000_0000, 64'h8000_0000_FFFF_FFFF, 2, 1, 1, "R6 negative clip");
    apply(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 3, 1, 1, "R6 64-bit negative clip");
    apply(64'h7FFF_8000_0001_FFFF, 64'h0001_8000_0001_0001, 1, 0, 1, "R7 signed flags no clip");
    apply(64'h7FFF_8000_0001_FFFF, 64'h0001_8000_0001_0001, 1, 0, 0, "R7 unsigned flags no clip");
    apply(64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 3, 0, 1, "R8 single flag bit");
    apply(64'hFFFF_FFFF_0000_0000, 64'h0000_0001_0000_0000, 2, 0, 0, "R8 upper lane flag bit1");

    for (int i = 0; i < 3000; i++) begin
      a = {$urandom, $urandom}; b = {$urandom, $urandom};
      sel = $urandom % 4;
      if (sel == 1) begin a = a | 64'h7F7F_7F7F_7F7F_7F7F; b = b | 64'h0101_0101_0101_0101; end
      if (sel == 2) begin a = a | 64'h8080_8080_8080_8080; b = b | 64'h8080_8080_8080_8080; end
      m = $urandom % 4; sat = $urandom % 2; sgn = $urandom % 2;
      if (!sat)      apply(a, b, m, sat, sgn, "R3 random wrap");
      else if (!sgn) apply(a, b, m, sat, sgn, "R4 random unsigned clip");
      else           apply(a, b, m, sat, sgn, "R5 random signed clip");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule